// File: doc/BRIEF.md
# Decode Stage Skid Controller

This block is the control core of a single-thread decode stage. Each cycle it takes a bundle of up to `LANES` instruction tokens from fetch and passes the live ones on to rename. A token is a sequence number plus a kill flag. Tokens with the kill flag set are dropped and take no output slot. The surviving tokens are packed into the lowest output slots, oldest first.

When rename signals a stall, the stage holds its input in a skid buffer and tells fetch to hold. When rename releases the stall, the stage first empties the skid buffer, oldest token first. Input that arrives during that drain is queued behind the buffered tokens. The stage sends a resume pulse to fetch only when the buffer is empty. A squash from commit overrides everything else: it discards all held and arriving tokens.

The control machine has five states, encoded on `stage_state`: IDLE=0, RUNNING=1, BLOCKED=2, UNBLOCKING=3, SQUASHING=4. The named transitions are:
- *wake*: IDLE to RUNNING.
- *settle*: RUNNING to IDLE.
- *stall*: RUNNING, IDLE, UNBLOCKING or SQUASHING to BLOCKED.
- *release*: BLOCKED to UNBLOCKING. The drain begins in the release cycle itself.
- *drained*: UNBLOCKING to RUNNING.
- *flush*: any state to SQUASHING.
- *recover*: SQUASHING to RUNNING.

Top module: `decode_skid_stage`

## Requirements
- R1: After reset the state is IDLE (0). `rn_cnt`, `fe_hold`, `fe_resume` and both error flags are 0.
- R2: In IDLE or RUNNING without a stall, the tokens of a bundle (`fe_cnt` at most `LANES`) appear on `rn_cnt`/`rn_seq` on the next edge, in slot order, and the state becomes RUNNING. A cycle with `fe_cnt`=0 moves RUNNING to IDLE. Unused slots read 0.
- R3: A token whose bit in `fe_kill` is 1 is dropped. The remaining tokens occupy slots 0 upward with no gaps, in input order.
- R4: A `rn_stall` pulse moves the state to BLOCKED with no output. The bundle of that cycle goes into the skid buffer. `fe_hold` pulses for one cycle, on entry to BLOCKED only.
- R5: A `rn_release` pulse while BLOCKED starts draining in the same cycle, with the state becoming UNBLOCKING. At most `LANES` tokens leave the buffer per cycle, oldest first. New bundles are appended behind the held tokens.
- R6: When the buffer is empty at the end of a drain cycle, `fe_resume` pulses for one cycle and the state becomes RUNNING.
- R7: `rn_stall` and `rn_release` in the same cycle leave no stall pending. That bundle is passed through as in R2.
- R8: `rn_release` with no stall pending and no `rn_stall` in the same cycle sets the sticky flag `err_release`.
- R9: `cm_squash` takes priority over any stall. It empties the skid buffer, drops the arriving bundle, produces no output and moves the state to SQUASHING. It pulses `fe_resume` if the state was BLOCKED or UNBLOCKING. `fe_hold` stays 0. A squash does not clear a pending stall.
- R10: SQUASHING lasts one cycle and then becomes RUNNING, unless a stall is pending.
- R11: The skid buffer holds `SKID_DEPTH` tokens, with `SKID_DEPTH` at least 2×`LANES`. Tokens beyond that limit are lost, and the sticky flag `err_overflow` is set.
- R12: While a stall stays pending, the state stays BLOCKED. Each arriving bundle is buffered, and `fe_hold` does not pulse again.
- R13: `fe_hold` is only seen in BLOCKED, and `fe_resume` only in RUNNING or SQUASHING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_cnt | input | $clog2(LANES+1) | Number of tokens in the fetch bundle |
| fe_seq | input | LANES*SEQ_W | Bundle sequence numbers, slot i at [i*SEQ_W +: SEQ_W] |
| fe_kill | input | LANES | Per-slot kill flag |
| rn_stall | input | 1 | Stall pulse from rename |
| rn_release | input | 1 | Release pulse from rename |
| cm_squash | input | 1 | Squash from commit |
| rn_cnt | output | $clog2(LANES+1) | Number of tokens sent to rename |
| rn_seq | output | LANES*SEQ_W | Sequence numbers sent to rename, packed from slot 0 |
| fe_hold | output | 1 | Hold pulse to fetch |
| fe_resume | output | 1 | Resume pulse to fetch |
| stage_state | output | 3 | Control state |
| err_overflow | output | 1 | Sticky skid overflow flag |
| err_release | output | 1 | Sticky release-without-stall flag |

## Verification
Every result of this block comes from one register stage. The tokens on the rename side, the hold and resume pulses, the state code and both error flags all reflect the inputs present at the preceding rising edge. None of them changes combinationally. The bench therefore applies one bundle and its control pulses at a falling edge. It samples all outputs shortly after the next rising edge and checks them against values worked out for that single edge. Multi-cycle behaviour, such as a drain spread over several cycles or recovery after a squash, is checked one edge at a time, with a fresh stimulus and a fresh sample per edge.

// File: rtl/decode_skid_pkg.sv
package decode_skid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } stage_state_e;

endpackage

// File: rtl/dsk_pack.sv
module dsk_pack #(
    parameter int LANES = 4,
    parameter int SEQ_W = 16,
    localparam int BC_W = $clog2(LANES + 1)
) (
    input  logic [BC_W-1:0]        in_cnt,
    input  logic [LANES*SEQ_W-1:0] in_seq,
    input  logic [LANES-1:0]       in_kill,
    output logic [SEQ_W-1:0]       pk_seq [LANES],
    output logic [BC_W-1:0]        pk_cnt
);

    int k;

    always_comb begin
        k = 0;
        for (int i = 0; i < LANES; i++) begin
            pk_seq[i] = '0;
        end
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(in_cnt) && !in_kill[i] && k < LANES) begin
                pk_seq[k] = in_seq[i*SEQ_W +: SEQ_W];
                k = k + 1;
            end
        end
        pk_cnt = BC_W'(k);
    end

endmodule

// File: rtl/dsk_fifo.sv
module dsk_fifo #(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int BC_W  = $clog2(LANES + 1),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [BC_W-1:0]  push_cnt,
    input  logic [SEQ_W-1:0] push_seq [LANES],
    input  logic [BC_W-1:0]  pop_cnt,
    output logic [SEQ_W-1:0] head_seq [LANES],
    output logic [LVL_W-1:0] level,
    output logic             ovf
);

    logic [SEQ_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [LVL_W-1:0] lvl_q;
    int unsigned      space, push_acc;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int unsigned k);
        int unsigned s;
        s = 32'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    always_comb begin
        space    = DEPTH - 32'(lvl_q) + 32'(pop_cnt);
        push_acc = (32'(push_cnt) > space) ? space : 32'(push_cnt);
        ovf      = !clear && (32'(push_cnt) > space);
        for (int i = 0; i < LANES; i++) begin
            head_seq[i] = mem[adv(rd_q, i)];
        end
    end

    assign level = lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
        end else begin
            rd_q  <= adv(rd_q, 32'(pop_cnt));
            wr_q  <= adv(wr_q, push_acc);
            lvl_q <= LVL_W'(32'(lvl_q) - 32'(pop_cnt) + push_acc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !clear) begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(push_acc)) mem[adv(wr_q, i)] <= push_seq[i];
            end
        end
    end

    assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LVL_W'(DEPTH));

    assert_pop_le_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pop_cnt) <= 32'(lvl_q));

endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
    import decode_skid_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    localparam int BC_W  = $clog2(LANES + 1),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk,
    input  logic             rel,
    input  logic             squash,
    input  logic             raw_any,
    input  logic [BC_W-1:0]  pk_cnt,
    input  logic [LVL_W-1:0] skid_level,
    output stage_state_e     state_q,
    output logic [BC_W-1:0]  pop_cnt,
    output logic [BC_W-1:0]  push_cnt,
    output logic             clear,
    output logic             from_skid,
    output logic [BC_W-1:0]  out_cnt,
    output logic             hold_p,
    output logic             resume_p,
    output logic             rel_err
);

    stage_state_e state_d;
    logic         stall_q, stall_d;
    int unsigned  take, remain;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stall_q <= 1'b0;
        end else begin
            state_q <= state_d;
            stall_q <= stall_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        stall_d   = rel ? 1'b0 : (stall_q | blk);
        rel_err   = rel & ~stall_q & ~blk;
        pop_cnt   = '0;
        push_cnt  = '0;
        clear     = 1'b0;
        from_skid = 1'b0;
        out_cnt   = '0;
        hold_p    = 1'b0;
        resume_p  = 1'b0;
        take      = (32'(skid_level) > LANES) ? LANES : 32'(skid_level);
        remain    = 32'(skid_level) - take + 32'(pk_cnt);
        if (squash) begin
            state_d  = ST_SQUASH;
            clear    = 1'b1;
            resume_p = (state_q == ST_BLOCK) || (state_q == ST_UNBLK);
        end else if (stall_d) begin
            state_d  = ST_BLOCK;
            push_cnt = pk_cnt;
            hold_p   = (state_q != ST_BLOCK);
        end else begin
            unique case (state_q)
                ST_BLOCK, ST_UNBLK: begin
                    from_skid = 1'b1;
                    pop_cnt   = BC_W'(take);
                    out_cnt   = BC_W'(take);
                    push_cnt  = pk_cnt;
                    if (remain == 0) begin
                        resume_p = 1'b1;
                        state_d  = ST_RUN;
                    end else begin
                        state_d  = ST_UNBLK;
                    end
                end
                ST_IDLE, ST_RUN: begin
                    out_cnt = pk_cnt;
                    state_d = raw_any ? ST_RUN : ST_IDLE;
                end
                ST_SQUASH: begin
                    out_cnt = pk_cnt;
                    state_d = ST_RUN;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assert_squash_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> state_q == ST_SQUASH);

    assert_squash_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASH && !squash && (rel || !(stall_q || blk))) |=> state_q == ST_RUN);

    assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && !rel && !squash) |=> state_q == ST_BLOCK);

endmodule

// File: rtl/decode_skid_stage.sv
module decode_skid_stage
    import decode_skid_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SEQ_W      = 16,
    parameter int SKID_DEPTH = 8,
    localparam int BC_W  = $clog2(LANES + 1),
    localparam int LVL_W = $clog2(SKID_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BC_W-1:0]        fe_cnt,
    input  logic [LANES*SEQ_W-1:0] fe_seq,
    input  logic [LANES-1:0]       fe_kill,
    input  logic                   rn_stall,
    input  logic                   rn_release,
    input  logic                   cm_squash,
    output logic [BC_W-1:0]        rn_cnt,
    output logic [LANES*SEQ_W-1:0] rn_seq,
    output logic                   fe_hold,
    output logic                   fe_resume,
    output logic [2:0]             stage_state,
    output logic                   err_overflow,
    output logic                   err_release
);

    logic [SEQ_W-1:0] pk_seq   [LANES];
    logic [SEQ_W-1:0] head_seq [LANES];
    logic [SEQ_W-1:0] sel_seq  [LANES];
    logic [BC_W-1:0]  pk_cnt, pop_cnt, push_cnt, out_cnt;
    logic [LVL_W-1:0] skid_level;
    logic             clear, from_skid, hold_p, resume_p, rel_err, ovf;
    stage_state_e     state_q;

    dsk_pack #(.LANES(LANES), .SEQ_W(SEQ_W)) u_pack (
        .in_cnt (fe_cnt),
        .in_seq (fe_seq),
        .in_kill(fe_kill),
        .pk_seq (pk_seq),
        .pk_cnt (pk_cnt)
    );

    dsk_fifo #(.LANES(LANES), .DEPTH(SKID_DEPTH), .SEQ_W(SEQ_W)) u_skid (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .push_cnt(push_cnt),
        .push_seq(pk_seq),
        .pop_cnt (pop_cnt),
        .head_seq(head_seq),
        .level   (skid_level),
        .ovf     (ovf)
    );

    dsk_ctrl #(.LANES(LANES), .DEPTH(SKID_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk       (rn_stall),
        .rel       (rn_release),
        .squash    (cm_squash),
        .raw_any   (fe_cnt != '0),
        .pk_cnt    (pk_cnt),
        .skid_level(skid_level),
        .state_q   (state_q),
        .pop_cnt   (pop_cnt),
        .push_cnt  (push_cnt),
        .clear     (clear),
        .from_skid (from_skid),
        .out_cnt   (out_cnt),
        .hold_p    (hold_p),
        .resume_p  (resume_p),
        .rel_err   (rel_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_sel
        assign sel_seq[g] = from_skid ? head_seq[g] : pk_seq[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rn_cnt       <= '0;
            rn_seq       <= '0;
            fe_hold      <= 1'b0;
            fe_resume    <= 1'b0;
            err_overflow <= 1'b0;
            err_release  <= 1'b0;
        end else begin
            rn_cnt <= out_cnt;
            for (int i = 0; i < LANES; i++) begin
                rn_seq[i*SEQ_W +: SEQ_W] <= (i < int'(out_cnt)) ? sel_seq[i] : '0;
            end
            fe_hold      <= hold_p;
            fe_resume    <= resume_p;
            err_overflow <= err_overflow | ovf;
            err_release  <= err_release | rel_err;
        end
    end

    assign stage_state = state_q;

    assert_out_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rn_cnt) <= LANES);

    assert_blocked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_state == 3'd2 |-> rn_cnt == '0);

    assert_hold_in_block_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fe_hold |-> stage_state == 3'd2);

    assert_resume_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fe_resume |-> (stage_state == 3'd1 || stage_state == 3'd4));

endmodule

// File: tb/sim_decode_skid_stage.sv
`timescale 1ns/100ps
module sim_decode_skid_stage;

    localparam int W  = 4;
    localparam int S  = 16;
    localparam int D  = 8;
    localparam int BC = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BC-1:0] fe_cnt = '0;
    logic [W*S-1:0] fe_seq = '0;
    logic [W-1:0]  fe_kill = '0;
    logic          rn_stall = 1'b0, rn_release = 1'b0, cm_squash = 1'b0;
    logic [BC-1:0] rn_cnt;
    logic [W*S-1:0] rn_seq;
    logic          fe_hold, fe_resume, err_overflow, err_release;
    logic [2:0]    stage_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    decode_skid_stage #(.LANES(W), .SEQ_W(S), .SKID_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .fe_cnt(fe_cnt), .fe_seq(fe_seq), .fe_kill(fe_kill),
        .rn_stall(rn_stall), .rn_release(rn_release), .cm_squash(cm_squash),
        .rn_cnt(rn_cnt), .rn_seq(rn_seq), .fe_hold(fe_hold), .fe_resume(fe_resume),
        .stage_state(stage_state), .err_overflow(err_overflow), .err_release(err_release)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int slot(input int i);
        return int'(rn_seq[i*S +: S]);
    endfunction

    task automatic step(input int n, input int base, input logic [W-1:0] kill,
                        input logic b, input logic r, input logic s);
        @(negedge clk);
        fe_cnt = BC'(n);
        for (int i = 0; i < W; i++) fe_seq[i*S +: S] = S'(base + i);
        fe_kill = kill;
        rn_stall = b; rn_release = r; cm_squash = s;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fe_cnt = '0; fe_kill = '0; rn_stall = 0; rn_release = 0; cm_squash = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 state", int'(stage_state), 0);
        chk("R1 rn_cnt", int'(rn_cnt), 0);
        chk("R1 hold", int'(fe_hold), 0);
        chk("R1 resume", int'(fe_resume), 0);
        chk("R1 errors", int'(err_overflow) + int'(err_release), 0);
    endtask

    task automatic t_run();
        step(4, 100, 4'b0000, 0, 0, 0);
        chk("R2 state run", int'(stage_state), 1);
        chk("R2 count", int'(rn_cnt), 4);
        for (int i = 0; i < W; i++) chk("R2 order", slot(i), 100 + i);
        step(2, 110, 4'b0000, 0, 0, 0);
        chk("R2 partial count", int'(rn_cnt), 2);
        chk("R2 unused slot zero", slot(2), 0);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R2 settle idle", int'(stage_state), 0);
        chk("R2 empty", int'(rn_cnt), 0);
    endtask

    task automatic t_kill();
        step(4, 200, 4'b0101, 0, 0, 0);
        chk("R3 count", int'(rn_cnt), 2);
        chk("R3 slot0", slot(0), 201);
        chk("R3 slot1", slot(1), 203);
        step(4, 210, 4'b1111, 0, 0, 0);
        chk("R3 all killed", int'(rn_cnt), 0);
        step(0, 0, 4'b0000, 0, 0, 0);
    endtask

    task automatic t_block_drain();
        step(3, 300, 4'b0000, 1, 0, 0);
        chk("R4 state", int'(stage_state), 2);
        chk("R4 no out", int'(rn_cnt), 0);
        chk("R4 hold pulse", int'(fe_hold), 1);
        step(2, 303, 4'b0000, 0, 0, 0);
        chk("R12 still blocked", int'(stage_state), 2);
        chk("R12 no re-hold", int'(fe_hold), 0);
        chk("R12 no out", int'(rn_cnt), 0);
        step(0, 0, 4'b0000, 0, 1, 0);
        chk("R5 state unblk", int'(stage_state), 3);
        chk("R5 count", int'(rn_cnt), 4);
        for (int i = 0; i < W; i++) chk("R5 oldest first", slot(i), 300 + i);
        chk("R5 no early resume", int'(fe_resume), 0);
        step(2, 305, 4'b0000, 0, 0, 0);
        chk("R5 leftover count", int'(rn_cnt), 1);
        chk("R5 leftover", slot(0), 304);
        chk("R5 still unblk", int'(stage_state), 3);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R6 appended count", int'(rn_cnt), 2);
        chk("R6 appended 0", slot(0), 305);
        chk("R6 appended 1", slot(1), 306);
        chk("R6 resume", int'(fe_resume), 1);
        chk("R6 running", int'(stage_state), 1);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R6 resume one cycle", int'(fe_resume), 0);
    endtask

    task automatic t_same_cycle();
        step(1, 400, 4'b0000, 1, 1, 0);
        chk("R7 running", int'(stage_state), 1);
        chk("R7 passed", slot(0), 400);
        chk("R7 no hold", int'(fe_hold), 0);
        chk("R7 no error", int'(err_release), 0);
        step(0, 0, 4'b0000, 0, 0, 0);
    endtask

    task automatic t_squash();
        step(2, 500, 4'b0000, 1, 0, 0);
        chk("R9 pre blocked", int'(stage_state), 2);
        step(2, 502, 4'b0000, 0, 1, 1);
        chk("R9 squashing", int'(stage_state), 4);
        chk("R9 resume from blocked", int'(fe_resume), 1);
        chk("R9 no out", int'(rn_cnt), 0);
        chk("R9 no hold", int'(fe_hold), 0);
        step(1, 600, 4'b0000, 0, 0, 0);
        chk("R10 running", int'(stage_state), 1);
        chk("R9 skid cleared count", int'(rn_cnt), 1);
        chk("R9 skid cleared seq", slot(0), 600);
        step(2, 700, 4'b0000, 0, 0, 1);
        chk("R9 squash from run", int'(stage_state), 4);
        chk("R9 no resume from run", int'(fe_resume), 0);
        chk("R9 dropped", int'(rn_cnt), 0);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R10 recover", int'(stage_state), 1);
        step(1, 800, 4'b0000, 1, 0, 1);
        chk("R9 priority over stall", int'(stage_state), 4);
        chk("R9 no hold on squash", int'(fe_hold), 0);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R9 stall survives squash", int'(stage_state), 2);
        step(0, 0, 4'b0000, 0, 1, 0);
        chk("R6 empty release resumes", int'(fe_resume), 1);
        step(0, 0, 4'b0000, 0, 0, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        step(4, 900, 4'b0000, 1, 0, 0);
        step(4, 904, 4'b0000, 0, 0, 0);
        chk("R11 full no error", int'(err_overflow), 0);
        step(1, 908, 4'b0000, 0, 0, 0);
        chk("R11 overflow flag", int'(err_overflow), 1);
        step(0, 0, 4'b0000, 0, 1, 0);
        for (int i = 0; i < W; i++) chk("R11 kept order", slot(i), 900 + i);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R11 last kept", slot(3), 907);
        chk("R11 extra lost", int'(stage_state), 1);
        chk("R11 sticky", int'(err_overflow), 1);
    endtask

    task automatic t_rel_err();
        do_reset();
        step(0, 0, 4'b0000, 0, 1, 0);
        chk("R8 error set", int'(err_release), 1);
        step(0, 0, 4'b0000, 0, 0, 0);
        chk("R8 sticky", int'(err_release), 1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_run();
        t_kill();
        t_block_drain();
        t_same_cycle();
        chk("R8 clean so far", int'(err_release), 0);
        t_squash();
        chk("R11 no overflow in normal use", int'(err_overflow), 0);
        t_overflow();
        t_rel_err();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule